// File: doc/BRIEF.md
# Mode Register and Burst Column Sequencer

This block sits in a DDR memory command path. It captures register-set commands into either a main mode word or an extended mode word, chosen by the two bank-select bits. From the stored main mode word it takes the burst length (2, 4 or 8 beats) and the wrap order (sequential or interleaved). On each burst request it then emits one column address per clock, starting from a given column.

After every accepted register write, the block holds off further commands for two clocks and raises a blocked flag while it does so. For read bursts it produces a data output-enable window that opens three clocks after the accepted start, matching a read latency of three. The window closes once the last beat has left, so the data bus is released.

The block also flags register settings it cannot honour. It refuses a burst request made before the main mode word has been written, or while the stored burst length is not usable.

Top module: `mode_burst_seq`

## Requirements
- R1: A register-set strobe with `bank_sel` = 2'b00 writes `addr_in` into the main mode word, and `bank_sel` = 2'b01 writes it into the extended mode word, which is visible on `ext_mode` from the next cycle. `bank_sel` values 2'b10 and 2'b11 write nothing and start no hold-off.
- R2: Main mode word layout: bits [2:0] hold the burst-length code, bit [3] holds the wrap order (0 sequential, 1 interleaved), bits [6:4] hold the read latency code, and bits [12:7] have no effect.
- R3: Burst-length codes 3'b001, 3'b010 and 3'b011 give 2, 4 and 8 beats. `burst_active` is high for exactly that many cycles, beginning in the cycle after the accepted start.
- R4: In sequential order, beat n carries the starting column with its low log2(length) bits replaced by (start low bits + n) modulo the length.
- R5: In interleaved order, beat n carries the starting column with its low log2(length) bits XORed with n.
- R6: Once the main mode word has been written, `cfg_illegal` is high whenever its burst-length code is not 001/010/011 or its latency code is not 3'b011. Before any write it is low. A bad latency code alone does not stop bursts.
- R7: After an accepted register write, `cmd_blocked` is high for the next 2 cycles. Register-set strobes and burst requests presented at the two clock edges that follow the write are ignored. A burst request at the third edge is accepted.
- R8: For a read burst (`burst_rd` = 1) accepted at edge k, `dq_oe` is high for exactly as many cycles as the burst has beats, starting in the cycle after edge k+3. A write burst never raises `dq_oe`.
- R9: A burst request made while the main mode word has never been written, or while its length code is illegal, starts no burst. It pulses `req_err` for one cycle, in the cycle after the request.
- R10: Column bits above bit 2 stay equal to the starting column for the whole burst, and `col_addr` is zero while no burst is active.
- R11: Burst requests and register-set strobes that arrive while a burst is active are ignored.
- R12: After reset, all outputs are zero and neither mode word holds a valid setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_mrs | input | 1 | Register-set command strobe |
| bank_sel | input | 2 | Selects the target mode word |
| addr_in | input | 13 | Value to write into the selected mode word |
| burst_go | input | 1 | Burst request |
| burst_rd | input | 1 | 1 for a read burst, 0 for a write burst |
| start_col | input | COL_W | Starting column of the burst |
| col_addr | output | COL_W | Column address of the current beat |
| burst_active | output | 1 | A burst beat is being issued |
| cmd_blocked | output | 1 | Hold-off after a register write |
| dq_oe | output | 1 | Read data output-enable window |
| cfg_illegal | output | 1 | Stored main mode word is unusable or off-spec |
| req_err | output | 1 | One-cycle pulse for a refused burst request |
| ext_mode | output | 13 | Stored extended mode word |

## Verification
The assertions assume that `cmd_mrs` and `burst_go` stay low while reset is applied. The output-enable check counts on a read latency that is fixed at three and that no new burst starts until the previous one has ended. The stimulus drives every input on the falling edge and releases each strobe after one cycle. Requests during a burst or during the hold-off are sent on purpose only in the directed tests that check those requests are ignored.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int MR_W  = 13;
    localparam int LOW_W = 3;
    localparam int RD_LAT = 3;
    localparam logic [2:0] LAT_CODE_OK = 3'd3;
    localparam logic [1:0] SEL_MAIN = 2'b00;
    localparam logic [1:0] SEL_EXT  = 2'b01;

    typedef struct packed {
        logic [5:0] spare;
        logic [2:0] lat;
        logic       wrap;
        logic [2:0] blen;
    } mode_word_t;

    typedef enum logic {ORDER_SEQ = 1'b0, ORDER_ILV = 1'b1} order_e;

    function automatic logic blen_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [LOW_W-1:0] low_mask(input logic [1:0] lg);
        logic [3:0] full;
        full = (4'd1 << lg) - 4'd1;
        return full[LOW_W-1:0];
    endfunction

    function automatic logic [LOW_W-1:0] beat_offset(input logic [LOW_W-1:0] s,
                                                     input logic [LOW_W-1:0] b,
                                                     input logic [1:0] lg,
                                                     input order_e ord);
        logic [LOW_W-1:0] m;
        logic [LOW_W-1:0] r;
        m = low_mask(lg);
        if (ord == ORDER_SEQ) r = ((s + b) & m) | (s & ~m);
        else                  r = s ^ b;
        return r;
    endfunction

endpackage

// File: rtl/mbs_mode_regs.sv
module mbs_mode_regs
    import mbs_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_mrs,
    input  logic [1:0]       bank_sel,
    input  logic [MR_W-1:0]  addr_in,
    input  logic             busy,
    output mode_word_t       mr_q,
    output logic             mr_valid,
    output logic [MR_W-1:0]  emr_q,
    output logic             blocked
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);

    logic [CNT_W-1:0] gap_cnt;
    logic             wr_acc;

    assign blocked = (gap_cnt != '0);
    assign wr_acc  = !rst && cmd_mrs && !blocked && !busy &&
                     ((bank_sel == SEL_MAIN) || (bank_sel == SEL_EXT));

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_q     <= '0;
            mr_valid <= 1'b0;
            emr_q    <= '0;
            gap_cnt  <= '0;
        end else begin
            if (wr_acc) begin
                gap_cnt <= CNT_W'(GAP_CYC);
                if (bank_sel == SEL_MAIN) begin
                    mr_q     <= mode_word_t'(addr_in);
                    mr_valid <= 1'b1;
                end else begin
                    emr_q <= addr_in;
                end
            end else if (blocked) begin
                gap_cnt <= gap_cnt - 1'b1;
            end
        end
    end

    assert_gap_first_R7: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> blocked);
    assert_gap_second_R7: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> ##1 blocked);
    assert_blocked_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_mrs && blocked) |=> ($stable(emr_q) && $stable(mr_q)));
endmodule

// File: rtl/mbs_burst_gen.sv
module mbs_burst_gen
    import mbs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       log2len,
    input  order_e           order,
    input  logic             rd,
    output logic             active,
    output logic [COL_W-1:0] col,
    output logic             act_rd
);
    logic [COL_W-1:0] base;
    logic [LOW_W-1:0] beat;
    logic [1:0]       lg;
    order_e           ord;
    logic             rd_q;
    logic             last;

    assign last   = (beat == low_mask(lg));
    assign act_rd = active && rd_q;
    assign col    = active ? {base[COL_W-1:LOW_W], beat_offset(base[LOW_W-1:0], beat, lg, ord)}
                           : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            beat   <= '0;
            lg     <= '0;
            ord    <= ORDER_SEQ;
            rd_q   <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            base   <= start_col;
            beat   <= '0;
            lg     <= log2len;
            ord    <= order;
            rd_q   <= rd;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      beat   <= beat + 1'b1;
        end
    end

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (col[COL_W-1:LOW_W] == $past(col[COL_W-1:LOW_W])));
    assert_start_idle_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
endmodule

// File: rtl/mbs_oe_pipe.sv
module mbs_oe_pipe #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    output logic oe_o
);
    localparam int W_W = $clog2(DELAY + 1);

    logic [DELAY-1:0] stage;
    logic [W_W-1:0]   warm;

    assign oe_o = stage[DELAY-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            warm  <= '0;
        end else begin
            stage <= {stage[DELAY-2:0], rd_i};
            if (warm != W_W'(DELAY)) warm <= warm + 1'b1;
        end
    end

    assert_oe_window_R8: assert property (@(posedge clk) disable iff (rst)
        (warm == W_W'(DELAY)) |-> (oe_o == $past(rd_i, DELAY)));
endmodule

// File: rtl/mode_burst_seq.sv
module mode_burst_seq
    import mbs_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_mrs,
    input  logic [1:0]       bank_sel,
    input  logic [12:0]      addr_in,
    input  logic             burst_go,
    input  logic             burst_rd,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] col_addr,
    output logic             burst_active,
    output logic             cmd_blocked,
    output logic             dq_oe,
    output logic             cfg_illegal,
    output logic             req_err,
    output logic [12:0]      ext_mode
);
    mode_word_t mr;
    logic       mr_valid;
    logic       go_acc;
    logic       cfg_good;
    logic       start;
    logic       act_rd;

    mbs_mode_regs #(.GAP_CYC(GAP_CYC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd_mrs  (cmd_mrs),
        .bank_sel (bank_sel),
        .addr_in  (addr_in),
        .busy     (burst_active),
        .mr_q     (mr),
        .mr_valid (mr_valid),
        .emr_q    (ext_mode),
        .blocked  (cmd_blocked)
    );

    assign go_acc      = burst_go && !cmd_blocked && !burst_active;
    assign cfg_good    = mr_valid && blen_ok(mr.blen);
    assign start       = go_acc && cfg_good;
    assign cfg_illegal = mr_valid && (!blen_ok(mr.blen) || (mr.lat != LAT_CODE_OK));

    always_ff @(posedge clk) begin
        if (rst) req_err <= 1'b0;
        else     req_err <= go_acc && !cfg_good;
    end

    mbs_burst_gen #(.COL_W(COL_W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .log2len   (mr.blen[1:0]),
        .order     (order_e'(mr.wrap)),
        .rd        (burst_rd),
        .active    (burst_active),
        .col       (col_addr),
        .act_rd    (act_rd)
    );

    mbs_oe_pipe #(.DELAY(RD_LAT)) u_oe (
        .clk  (clk),
        .rst  (rst),
        .rd_i (act_rd),
        .oe_o (dq_oe)
    );

    assert_refuse_no_burst_R9: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !burst_active);
    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        req_err |=> !req_err || $past(burst_go));
endmodule

// File: tb/mode_burst_seq_tb_top.sv
module mode_burst_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int COL_W = 10;
    localparam int NVEC  = 6;
    localparam int VW    = 95;

    // {blen code, wrap, rd, start, expected beat 0..7}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {3'd1, 1'b0, 1'b1, 10'h005, 10'h005, 10'h004, 60'h0},
        {3'd2, 1'b0, 1'b1, 10'h0A6, 10'h0A6, 10'h0A7, 10'h0A4, 10'h0A5, 40'h0},
        {3'd3, 1'b0, 1'b1, 10'h3FD, 10'h3FD, 10'h3FE, 10'h3FF, 10'h3F8,
                                    10'h3F9, 10'h3FA, 10'h3FB, 10'h3FC},
        {3'd3, 1'b1, 1'b0, 10'h12B, 10'h12B, 10'h12A, 10'h129, 10'h128,
                                    10'h12F, 10'h12E, 10'h12D, 10'h12C},
        {3'd2, 1'b1, 1'b1, 10'h201, 10'h201, 10'h200, 10'h203, 10'h202, 40'h0},
        {3'd1, 1'b1, 1'b0, 10'h0FF, 10'h0FF, 10'h0FE, 60'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_mrs = 1'b0;
    logic [1:0] bank_sel = 2'b00;
    logic [12:0] addr_in = '0;
    logic burst_go = 1'b0;
    logic burst_rd = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] col_addr;
    logic burst_active, cmd_blocked, dq_oe, cfg_illegal, req_err;
    logic [12:0] ext_mode;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    mode_burst_seq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst(rst), .cmd_mrs(cmd_mrs), .bank_sel(bank_sel),
        .addr_in(addr_in), .burst_go(burst_go), .burst_rd(burst_rd),
        .start_col(start_col), .col_addr(col_addr), .burst_active(burst_active),
        .cmd_blocked(cmd_blocked), .dq_oe(dq_oe), .cfg_illegal(cfg_illegal),
        .req_err(req_err), .ext_mode(ext_mode)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] b, input logic [12:0] a);
        cmd_mrs = 1'b1; bank_sel = b; addr_in = a;
        tick();
        cmd_mrs = 1'b0;
    endtask

    task automatic run_vec(input logic [VW-1:0] v);
        logic [2:0] bl;
        int len;
        bl  = v[94:92];
        len = 1 << bl;
        wr_reg(2'b00, {6'd0, 3'd3, v[91], bl});
        chk("R7 blocked after write", cmd_blocked, 1);
        tick(); tick();
        chk("R6 legal word", cfg_illegal, 0);
        burst_go = 1'b1; burst_rd = v[90]; start_col = v[89:80];
        tick();
        burst_go = 1'b0;
        for (int i = 0; i < len + 4; i++) begin
            chk("R3 active span", burst_active, (i < len));
            if (i < len) chk(v[91] ? "R5 interleave col" : "R4 sequential col",
                             col_addr, v[79 - 10*i -: 10]);
            else         chk("R10 idle col zero", col_addr, 0);
            chk("R8 oe window", dq_oe, v[90] && (i >= 3) && (i < 3 + len));
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R12 reset state
        chk("R12 col", col_addr, 0);
        chk("R12 active", burst_active, 0);
        chk("R12 blocked", cmd_blocked, 0);
        chk("R12 oe", dq_oe, 0);
        chk("R12 illegal", cfg_illegal, 0);
        chk("R12 err", req_err, 0);
        chk("R12 ext", ext_mode, 0);

        // R9: request before main word written
        burst_go = 1'b1; start_col = 10'h010;
        tick();
        burst_go = 1'b0;
        chk("R9 err pulse", req_err, 1);
        chk("R9 no burst", burst_active, 0);
        tick();
        chk("R9 err one cycle", req_err, 0);

        // R1: extended word write
        wr_reg(2'b01, 13'h1ABC);
        chk("R1 ext written", ext_mode, 13'h1ABC);
        chk("R7 blocked ext", cmd_blocked, 1);
        tick(); tick();
        chk("R6 low before main write", cfg_illegal, 0);
        burst_go = 1'b1;
        tick();
        burst_go = 1'b0;
        chk("R9 still refused", req_err, 1);
        tick();

        // R1: bank select 2'b10 writes nothing, no hold-off
        wr_reg(2'b10, 13'h0055);
        chk("R1 sel10 ext kept", ext_mode, 13'h1ABC);
        chk("R1 sel10 no block", cmd_blocked, 0);
        tick();

        // Table of bursts: R3 R4 R5 R8 R10
        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R7: hold-off window
        wr_reg(2'b00, {6'd0, 3'd3, 1'b0, 3'd2});
        burst_go = 1'b1; burst_rd = 1'b0; start_col = 10'h100;
        tick();
        burst_go = 1'b0;
        chk("R7 go ignored edge1", burst_active, 0);
        chk("R7 still blocked", cmd_blocked, 1);
        cmd_mrs = 1'b1; bank_sel = 2'b01; addr_in = 13'h0777;
        tick();
        cmd_mrs = 1'b0;
        chk("R7 write ignored edge2", ext_mode, 13'h1ABC);
        chk("R7 released", cmd_blocked, 0);
        burst_go = 1'b1;
        tick();
        burst_go = 1'b0;
        chk("R7 go accepted edge3", burst_active, 1);
        chk("R7 first col", col_addr, 10'h100);
        repeat (6) tick();

        // R11: requests during a burst are ignored
        wr_reg(2'b00, {6'd0, 3'd3, 1'b0, 3'd3});
        tick(); tick();
        burst_go = 1'b1; burst_rd = 1'b0; start_col = 10'h040;
        tick();
        burst_go = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R11 col unaffected", col_addr, 10'h040 + i);
            if (i == 2) begin
                burst_go = 1'b1; start_col = 10'h3FF;
                cmd_mrs = 1'b1; bank_sel = 2'b01; addr_in = 13'h0AAA;
            end
            tick();
            burst_go = 1'b0; cmd_mrs = 1'b0;
        end
        chk("R11 burst ended", burst_active, 0);
        chk("R11 ext unchanged", ext_mode, 13'h1ABC);
        chk("R11 no hold-off", cmd_blocked, 0);
        tick();

        // R2 R6: bad latency code flagged, burst still runs
        wr_reg(2'b00, {6'd0, 3'd2, 1'b0, 3'd2});
        tick(); tick();
        chk("R6 bad latency", cfg_illegal, 1);
        burst_go = 1'b1; start_col = 10'h00C;
        tick();
        burst_go = 1'b0;
        chk("R6 burst despite latency", burst_active, 1);
        chk("R2 latency field only", req_err, 0);
        repeat (5) tick();

        // R6 R9: bad length code refused
        wr_reg(2'b00, {6'd0, 3'd3, 1'b0, 3'd4});
        tick(); tick();
        chk("R6 bad length", cfg_illegal, 1);
        burst_go = 1'b1;
        tick();
        burst_go = 1'b0;
        chk("R9 bad length err", req_err, 1);
        chk("R9 bad length no burst", burst_active, 0);
        tick();

        // R2: spare bits have no effect
        wr_reg(2'b00, 13'h1F80 | {6'd0, 3'd3, 1'b0, 3'd2});
        tick(); tick();
        chk("R2 spare ignored", cfg_illegal, 0);
        burst_go = 1'b1; start_col = 10'h2A7;
        tick();
        burst_go = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R2 spare len4", burst_active, (i < 4));
            if (i < 4) chk("R2 spare seq col", col_addr, {8'hA9, 2'(2'd3 + i)});
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule